// File: doc/BRIEF.md
# Cycle-Exact 8-Bit Load Sequencer

This block is the fetch and execute engine for the register-load subset of a small 8-bit processor. It holds three 8-bit data registers (A, X, Y), a 16-bit program counter and an 8-bit status word. It fetches opcodes and operands over a read-only, synchronous 8-bit memory port, forms the effective address and writes the loaded byte into the destination register. Only the negative and zero flags are updated.

One bus cycle lasts two clocks. An internal phase bit works as a clock enable, so the memory has a full clock to return data. Every instruction takes a fixed number of bus cycles, set by its addressing mode, whether or not that mode needs a memory read in every cycle. A one-clock retire pulse marks the end of each instruction, so the timing can be checked from outside.

A status bit moves the direct page from $0000 to $0100. An opcode outside the supported set stops the engine for good.

Top module: `ldseq_core`

## Requirements
- R1: While reset is held, PC and the memory address equal the START_PC parameter, A, X and Y are zero, the status word equals `cfg_psw`, `mem_rd` is 1 and `halted` is 0.
- R2: A bus cycle is two clocks. `mem_addr` changes only at the end of a bus cycle. `retire` is high for exactly one clock when an instruction finishes.
- R3: Loads into A take these bus-cycle counts. Immediate E8 takes 2. (X) E6 takes 3. (X)+ BF takes 4. dp E4 takes 3. dp+X F4 takes 4. abs E5 takes 4. abs+X F5 and abs+Y F6 take 5. [dp+X] E7 and [dp]+Y F7 take 6.
- R4: Loads into X are CD immediate (2 cycles), F8 dp (3), F9 dp+Y (4) and E9 abs (4). Loads into Y are 8D immediate (2), EB dp (3), FB dp+X (4) and EC abs (4).
- R5: The status word is N,V,P,H,B,I,Z,C from bit 7 to bit 0. Each load sets N (bit 7) to bit 7 of the loaded value and Z (bit 1) to whether the value is zero. It leaves the other six bits unchanged.
- R6: A direct-page offset addresses $0000+dp when status bit 5 (P) is 0, and $0100+dp when P is 1.
- R7: dp+index addresses wrap within the 256-byte page. abs+index addresses wrap modulo 65536 and carry into the high byte.
- R8: E6 reads from P*$100+X. BF reads the same address and then adds one to X, modulo 256. The flags reflect the loaded byte, not the new X.
- R9: [dp+X] adds X to the offset before it reads the 16-bit pointer. [dp]+Y reads the pointer and then adds Y. The pointer is little-endian, and its high byte comes from the next offset, wrapping within the page.
- R10: Absolute operands are little-endian. After an instruction, PC has advanced by the instruction's length: 1, 2 or 3 bytes.
- R11: An opcode outside the listed set raises `halted` for good, stops memory reads and retire pulses, and leaves A, X and Y unchanged. PC then points past the bad opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock (two per bus cycle) |
| rst | input | 1 | Synchronous active-high reset |
| cfg_psw | input | 8 | Status word loaded while reset is held |
| mem_addr | output | 16 | Read address for the current bus cycle |
| mem_rd | output | 1 | High when the current bus cycle reads memory |
| mem_rdata | input | 8 | Synchronous read data, one clock after the address |
| retire | output | 1 | One-clock pulse when an instruction completes |
| halted | output | 1 | Sticky flag after an unlisted opcode |
| pc_o | output | 16 | Program counter |
| a_o | output | 8 | Accumulator |
| x_o | output | 8 | X index register |
| y_o | output | 8 | Y index register |
| psw_o | output | 8 | Status word |

## Verification
Each register is loaded in turn with negative, zero and positive bytes, to show that the flags follow the data and that the untouched status bits keep a non-trivial pattern. Direct-page reads run with P both clear and set, over memory that holds different values at $00xx and $01xx, so a wrong page base returns a different byte. Indexed and pointer modes use offsets that cross $FF, absolute bases near $FFFF and pointer bases that need a carry, which separates in-page wrap from full 16-bit carry. The register-indirect tests step X through $FF and compare flags with X. A final program ends in an unlisted opcode to show the stop is permanent.

// File: rtl/ldseq_pkg.sv
package ldseq_pkg;

  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;

  // status word bit positions
  localparam int PSW_N = 7;
  localparam int PSW_P = 5;
  localparam int PSW_Z = 1;

  typedef enum logic [1:0] {
    DST_A,
    DST_X,
    DST_Y
  } dst_e;

  typedef enum logic [3:0] {
    AM_IMM,
    AM_XIND,
    AM_XINC,
    AM_DP,
    AM_DPI,
    AM_ABS,
    AM_ABSI,
    AM_IDXIND,
    AM_INDIDX
  } amode_e;

  typedef struct packed {
    logic   valid;
    dst_e   dst;
    amode_e mode;
    logic   idx_y;
  } dec_t;

  typedef enum logic [3:0] {
    ST_FETCH,
    ST_OPR1,
    ST_OPR2,
    ST_IDLE_PRE,
    ST_PLO,
    ST_PHI,
    ST_IDLE_POST,
    ST_READ,
    ST_XINC,
    ST_HALT
  } st_e;

endpackage

// File: rtl/ldseq_decode.sv
module ldseq_decode
  import ldseq_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic [DW-1:0] opcode,
  output dec_t          dec
);

  always_comb begin
    dec       = '0;
    dec.valid = 1'b1;
    case (opcode[7:0])
      8'hE8: begin dec.dst = DST_A; dec.mode = AM_IMM;    end
      8'hE6: begin dec.dst = DST_A; dec.mode = AM_XIND;   end
      8'hBF: begin dec.dst = DST_A; dec.mode = AM_XINC;   end
      8'hE4: begin dec.dst = DST_A; dec.mode = AM_DP;     end
      8'hF4: begin dec.dst = DST_A; dec.mode = AM_DPI;    end
      8'hE5: begin dec.dst = DST_A; dec.mode = AM_ABS;    end
      8'hF5: begin dec.dst = DST_A; dec.mode = AM_ABSI;   end
      8'hF6: begin dec.dst = DST_A; dec.mode = AM_ABSI;   dec.idx_y = 1'b1; end
      8'hE7: begin dec.dst = DST_A; dec.mode = AM_IDXIND; end
      8'hF7: begin dec.dst = DST_A; dec.mode = AM_INDIDX; dec.idx_y = 1'b1; end
      8'hCD: begin dec.dst = DST_X; dec.mode = AM_IMM;    end
      8'hF8: begin dec.dst = DST_X; dec.mode = AM_DP;     end
      8'hF9: begin dec.dst = DST_X; dec.mode = AM_DPI;    dec.idx_y = 1'b1; end
      8'hE9: begin dec.dst = DST_X; dec.mode = AM_ABS;    end
      8'h8D: begin dec.dst = DST_Y; dec.mode = AM_IMM;    end
      8'hEB: begin dec.dst = DST_Y; dec.mode = AM_DP;     end
      8'hFB: begin dec.dst = DST_Y; dec.mode = AM_DPI;    end
      8'hEC: begin dec.dst = DST_Y; dec.mode = AM_ABS;    end
      default: dec.valid = 1'b0;
    endcase
  end

endmodule

// File: rtl/ldseq_agen.sv
module ldseq_agen
  import ldseq_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          p_flag,
  input  logic [DW-1:0] x_reg,
  input  logic [DW-1:0] idx,
  input  logic [DW-1:0] rdata,
  input  logic [DW-1:0] t_lo,
  input  logic [DW-1:0] t_hi,
  input  logic [AW-1:0] cur_addr,
  output logic [AW-1:0] dp_dir,
  output logic [AW-1:0] dp_idx,
  output logic [AW-1:0] abs_dir,
  output logic [AW-1:0] abs_idx,
  output logic [AW-1:0] xind,
  output logic [AW-1:0] ptr_next
);

  localparam int PAD_W = AW - DW - 1;

  logic [DW-1:0] off_sum;
  logic [DW-1:0] ptr_off;

  always_comb begin
    off_sum  = t_lo + idx;                        // wraps inside the page
    ptr_off  = cur_addr[DW-1:0] + 1'b1;
    dp_dir   = {{PAD_W{1'b0}}, p_flag, rdata};
    dp_idx   = {{PAD_W{1'b0}}, p_flag, off_sum};
    xind     = {{PAD_W{1'b0}}, p_flag, x_reg};
    abs_dir  = AW'({rdata, t_lo});
    abs_idx  = AW'({t_hi, t_lo}) + AW'(idx);       // wraps modulo 2**AW
    ptr_next = {cur_addr[AW-1:DW], ptr_off};
  end

endmodule

// File: rtl/ldseq_regfile.sv
module ldseq_regfile
  import ldseq_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] psw_init,
  input  logic          ld_en,
  input  dst_e          ld_dst,
  input  logic [DW-1:0] ld_val,
  input  logic          x_inc,
  output logic [DW-1:0] a_q,
  output logic [DW-1:0] x_q,
  output logic [DW-1:0] y_q,
  output logic [DW-1:0] psw_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q   <= '0;
      x_q   <= '0;
      y_q   <= '0;
      psw_q <= psw_init;
    end else begin
      if (ld_en) begin
        case (ld_dst)
          DST_A:   a_q <= ld_val;
          DST_X:   x_q <= ld_val;
          default: y_q <= ld_val;
        endcase
        psw_q[PSW_N] <= ld_val[DW-1];
        psw_q[PSW_Z] <= (ld_val == '0);
      end
      if (x_inc) x_q <= x_q + 1'b1;
    end
  end

  a_r5_nz_follow: assert property (@(posedge clk) disable iff (rst)
    ld_en |=> (psw_q[PSW_N] == $past(ld_val[DW-1])) &&
              (psw_q[PSW_Z] == ($past(ld_val) == '0)));

  a_r5_others_kept: assert property (@(posedge clk) disable iff (rst)
    ld_en |=> (psw_q[6:2] == $past(psw_q[6:2])) && (psw_q[0] == $past(psw_q[0])));

  a_r8_x_step: assert property (@(posedge clk) disable iff (rst)
    x_inc |=> (x_q == $past(x_q) + 1'b1) && $stable(psw_q));

endmodule

// File: rtl/ldseq_core.sv
module ldseq_core
  import ldseq_pkg::*;
#(
  parameter int          AW       = ADDR_W,
  parameter int          DW       = DATA_W,
  parameter logic [15:0] START_PC = 16'hFFC0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] cfg_psw,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  input  logic [DW-1:0] mem_rdata,
  output logic          retire,
  output logic          halted,
  output logic [AW-1:0] pc_o,
  output logic [DW-1:0] a_o,
  output logic [DW-1:0] x_o,
  output logic [DW-1:0] y_o,
  output logic [DW-1:0] psw_o
);

  logic          ph;
  logic          ce;
  st_e           st, nx_st;
  dec_t          dq, dec_now;
  logic [AW-1:0] pc, addr, nx_addr;
  logic          rd, nx_rd;
  logic [DW-1:0] t_lo, t_hi;
  logic          retire_q, halted_q;

  logic          ld_c, xinc_c, fin, pc_step, lo_we, hi_we;
  logic [DW-1:0] idx;
  logic [AW-1:0] dp_dir, dp_idx, abs_dir, abs_idx, xind, ptr_next;

  assign ce = ph;

  ldseq_decode #(.DW(DW)) u_dec (
    .opcode (mem_rdata),
    .dec    (dec_now)
  );

  assign idx = dq.idx_y ? y_o : x_o;

  ldseq_agen #(.AW(AW), .DW(DW)) u_agen (
    .p_flag   (psw_o[PSW_P]),
    .x_reg    (x_o),
    .idx      (idx),
    .rdata    (mem_rdata),
    .t_lo     (t_lo),
    .t_hi     (t_hi),
    .cur_addr (addr),
    .dp_dir   (dp_dir),
    .dp_idx   (dp_idx),
    .abs_dir  (abs_dir),
    .abs_idx  (abs_idx),
    .xind     (xind),
    .ptr_next (ptr_next)
  );

  ldseq_regfile #(.DW(DW)) u_rf (
    .clk      (clk),
    .rst      (rst),
    .psw_init (cfg_psw),
    .ld_en    (ce & ld_c),
    .ld_dst   (dq.dst),
    .ld_val   (mem_rdata),
    .x_inc    (ce & xinc_c),
    .a_q      (a_o),
    .x_q      (x_o),
    .y_q      (y_o),
    .psw_q    (psw_o)
  );

  // micro-sequence: each state is one bus cycle
  always_comb begin
    nx_st   = st;
    nx_addr = addr;
    nx_rd   = 1'b1;
    ld_c    = 1'b0;
    xinc_c  = 1'b0;
    fin     = 1'b0;
    pc_step = 1'b0;
    lo_we   = 1'b0;
    hi_we   = 1'b0;
    case (st)
      ST_FETCH: begin
        pc_step = 1'b1;
        if (!dec_now.valid) begin
          nx_st = ST_HALT;
          nx_rd = 1'b0;
        end else if (dec_now.mode == AM_XIND || dec_now.mode == AM_XINC) begin
          nx_st = ST_IDLE_PRE;
          nx_rd = 1'b0;
        end else begin
          nx_st   = ST_OPR1;
          nx_addr = pc + 1'b1;
        end
      end
      ST_OPR1: begin
        pc_step = 1'b1;
        lo_we   = 1'b1;
        case (dq.mode)
          AM_IMM: begin
            ld_c    = 1'b1;
            fin     = 1'b1;
            nx_st   = ST_FETCH;
            nx_addr = pc + 1'b1;
          end
          AM_DP: begin
            nx_st   = ST_READ;
            nx_addr = dp_dir;
          end
          AM_DPI, AM_IDXIND: begin
            nx_st = ST_IDLE_PRE;
            nx_rd = 1'b0;
          end
          AM_INDIDX: begin
            nx_st   = ST_PLO;
            nx_addr = dp_dir;
          end
          default: begin
            nx_st   = ST_OPR2;
            nx_addr = pc + 1'b1;
          end
        endcase
      end
      ST_OPR2: begin
        pc_step = 1'b1;
        hi_we   = 1'b1;
        if (dq.mode == AM_ABSI) begin
          nx_st = ST_IDLE_PRE;
          nx_rd = 1'b0;
        end else begin
          nx_st   = ST_READ;
          nx_addr = abs_dir;
        end
      end
      ST_IDLE_PRE: begin
        case (dq.mode)
          AM_XIND, AM_XINC: begin nx_st = ST_READ; nx_addr = xind;    end
          AM_DPI:           begin nx_st = ST_READ; nx_addr = dp_idx;  end
          AM_ABSI:          begin nx_st = ST_READ; nx_addr = abs_idx; end
          default:          begin nx_st = ST_PLO;  nx_addr = dp_idx;  end
        endcase
      end
      ST_PLO: begin
        lo_we   = 1'b1;
        nx_st   = ST_PHI;
        nx_addr = ptr_next;
      end
      ST_PHI: begin
        hi_we = 1'b1;
        if (dq.mode == AM_IDXIND) begin
          nx_st   = ST_READ;
          nx_addr = abs_dir;
        end else begin
          nx_st = ST_IDLE_POST;
          nx_rd = 1'b0;
        end
      end
      ST_IDLE_POST: begin
        nx_st   = ST_READ;
        nx_addr = abs_idx;
      end
      ST_READ: begin
        ld_c = 1'b1;
        if (dq.mode == AM_XINC) begin
          nx_st = ST_XINC;
          nx_rd = 1'b0;
        end else begin
          fin     = 1'b1;
          nx_st   = ST_FETCH;
          nx_addr = pc;
        end
      end
      ST_XINC: begin
        xinc_c  = 1'b1;
        fin     = 1'b1;
        nx_st   = ST_FETCH;
        nx_addr = pc;
      end
      default: begin
        nx_st = ST_HALT;
        nx_rd = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph       <= 1'b0;
      st       <= ST_FETCH;
      dq       <= '0;
      pc       <= AW'(START_PC);
      addr     <= AW'(START_PC);
      rd       <= 1'b1;
      t_lo     <= '0;
      t_hi     <= '0;
      retire_q <= 1'b0;
      halted_q <= 1'b0;
    end else begin
      ph       <= ~ph;
      retire_q <= ce & fin;
      if (ce) begin
        st       <= nx_st;
        addr     <= nx_addr;
        rd       <= nx_rd;
        halted_q <= (nx_st == ST_HALT);
        if (pc_step) pc <= pc + 1'b1;
        if (lo_we) t_lo <= mem_rdata;
        if (hi_we) t_hi <= mem_rdata;
        if (st == ST_FETCH) dq <= dec_now;
      end
    end
  end

  assign mem_addr = addr;
  assign mem_rd   = rd;
  assign retire   = retire_q;
  assign halted   = halted_q;
  assign pc_o     = pc;

  a_r11_halt_sticky: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

  a_r11_halt_quiet: assert property (@(posedge clk) disable iff (rst)
    halted |-> !mem_rd && !retire);

  a_r11_live_op_valid: assert property (@(posedge clk) disable iff (rst)
    (st != ST_FETCH && st != ST_HALT) |-> dq.valid);

  a_r2_retire_single: assert property (@(posedge clk) disable iff (rst)
    retire |=> !retire);

  a_r2_addr_on_enable: assert property (@(posedge clk) disable iff (rst)
    !ce |=> $stable(mem_addr));

endmodule

// File: tb/ldseq_core_tb_top.sv
module ldseq_core_tb_top;

  localparam int          CLK_PERIOD = 10;
  localparam logic [15:0] PROG       = 16'h0600;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  cfg_psw = 8'h00;
  logic [15:0] mem_addr;
  logic        mem_rd;
  logic [7:0]  mem_rdata;
  logic        retire;
  logic        halted;
  logic [15:0] pc_o;
  logic [7:0]  a_o, x_o, y_o, psw_o;

  logic [7:0]  mem [0:2047];
  int          n_chk = 0;
  int          n_fail = 0;
  int          wp;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) mem_rdata <= mem[mem_addr[10:0]];

  ldseq_core #(.START_PC(PROG)) dut_i (
    .clk (clk), .rst (rst), .cfg_psw (cfg_psw),
    .mem_addr (mem_addr), .mem_rd (mem_rd), .mem_rdata (mem_rdata),
    .retire (retire), .halted (halted), .pc_o (pc_o),
    .a_o (a_o), .x_o (x_o), .y_o (y_o), .psw_o (psw_o)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic start(input logic [7:0] psw);
    @(negedge clk);
    rst     = 1'b1;
    cfg_psw = psw;
    for (int i = 0; i < 2048; i++) mem[i] = 8'(i) ^ 8'hA5;
    wp = int'(PROG);
    repeat (3) @(negedge clk);
  endtask

  task automatic put(input logic [7:0] b);
    mem[wp[10:0]] = b;
    wp++;
  endtask

  task automatic go();
    @(negedge clk);
    rst = 1'b0;
  endtask

  // runs one instruction and checks its length in bus cycles
  task automatic exec(input string req, input int ncyc);
    int cnt = 0;
    bit done = 0;
    for (int i = 0; i < 64 && !done; i++) begin
      @(posedge clk);
      cnt++;
      @(negedge clk);
      if (retire) done = 1;
    end
    check(req, "clocks", cnt, 2 * ncyc);
  endtask

  task automatic t_reset();
    start(8'h5D);
    put(8'hE8); put(8'h00);
    @(negedge clk);
    check("R1", "pc", pc_o, PROG);
    check("R1", "mem_addr", mem_addr, PROG);
    check("R1", "a", a_o, 0);
    check("R1", "x", x_o, 0);
    check("R1", "y", y_o, 0);
    check("R1", "psw", psw_o, 8'h5D);
    check("R1", "mem_rd", mem_rd, 1);
    check("R1", "halted", halted, 0);
    go();
    exec("R3", 2);
    check("R5", "psw zero load", psw_o, 8'h5F);
  endtask

  task automatic t_imm();
    start(8'h5F);
    put(8'hE8); put(8'h80);
    put(8'hCD); put(8'h7F);
    put(8'h8D); put(8'h00);
    go();
    exec("R3", 2);
    check("R3", "a imm", a_o, 8'h80);
    check("R5", "psw neg", psw_o, 8'hDD);
    exec("R4", 2);
    check("R4", "x imm", x_o, 8'h7F);
    check("R5", "psw pos", psw_o, 8'h5D);
    exec("R4", 2);
    check("R4", "y imm", y_o, 8'h00);
    check("R5", "psw zero", psw_o, 8'h5F);
    check("R10", "pc after 3 imm", pc_o, PROG + 6);
  endtask

  task automatic t_dp(input bit p);
    start(p ? 8'h20 : 8'h00);
    mem[11'h030] = 8'h11; mem[11'h130] = 8'h22;
    mem[11'h031] = 8'h81; mem[11'h131] = 8'h00;
    put(8'hE4); put(8'h30);
    put(8'hF8); put(8'h31);
    put(8'hEB); put(8'h31);
    go();
    exec("R3", 3);
    check("R6", "a dp", a_o, p ? 8'h22 : 8'h11);
    exec("R4", 3);
    check("R6", "x dp", x_o, p ? 8'h00 : 8'h81);
    check("R5", "psw x dp", psw_o, p ? 8'h22 : 8'h80);
    exec("R4", 3);
    check("R6", "y dp", y_o, p ? 8'h00 : 8'h81);
    check("R10", "pc dp", pc_o, PROG + 6);
  endtask

  task automatic t_dp_index();
    start(8'h00);
    mem[11'h010] = 8'h33; mem[11'h110] = 8'h44;
    mem[11'h022] = 8'h55; mem[11'h065] = 8'h66;
    put(8'hCD); put(8'h20);
    put(8'h8D); put(8'h05);
    put(8'hF4); put(8'hF0);
    put(8'hFB); put(8'h02);
    put(8'hF9); put(8'h10);
    go();
    exec("R4", 2);
    exec("R4", 2);
    exec("R3", 4);
    check("R7", "a dp+x page wrap", a_o, 8'h33);
    exec("R4", 4);
    check("R4", "y dp+x", y_o, 8'h55);
    exec("R4", 4);
    check("R4", "x dp+y", x_o, 8'h66);
  endtask

  task automatic t_abs();
    start(8'h00);
    mem[11'h534] = 8'h9A; mem[11'h345] = 8'h01;
    mem[11'h010] = 8'h3C; mem[11'h210] = 8'h77; mem[11'h110] = 8'hEE;
    put(8'hE5); put(8'h34); put(8'h05);
    put(8'hE9); put(8'h45); put(8'h03);
    put(8'hEC); put(8'h34); put(8'h05);
    put(8'hCD); put(8'h20);
    put(8'hF5); put(8'hF0); put(8'hFF);
    put(8'h8D); put(8'h30);
    put(8'hF6); put(8'hE0); put(8'h01);
    go();
    exec("R3", 4);
    check("R10", "a abs little-endian", a_o, 8'h9A);
    check("R10", "pc abs", pc_o, PROG + 3);
    exec("R4", 4);
    check("R4", "x abs", x_o, 8'h01);
    exec("R4", 4);
    check("R4", "y abs", y_o, 8'h9A);
    exec("R4", 2);
    exec("R3", 5);
    check("R7", "a abs+x 64K wrap", a_o, 8'h3C);
    exec("R4", 2);
    exec("R3", 5);
    check("R7", "a abs+y carry", a_o, 8'h77);
    check("R10", "pc abs run", pc_o, PROG + 19);
  endtask

  task automatic t_indirect();
    start(8'h00);
    mem[11'h014] = 8'h80; mem[11'h015] = 8'h03; mem[11'h380] = 8'hC1;
    mem[11'h0FF] = 8'h90; mem[11'h000] = 8'h02; mem[11'h100] = 8'h07;
    mem[11'h290] = 8'h5E; mem[11'h790] = 8'hEE;
    mem[11'h040] = 8'hF8; mem[11'h041] = 8'h02; mem[11'h308] = 8'h00;
    put(8'hCD); put(8'h04);
    put(8'hE7); put(8'h10);
    put(8'hCD); put(8'h0F);
    put(8'hE7); put(8'hF0);
    put(8'h8D); put(8'h10);
    put(8'hF7); put(8'h40);
    go();
    exec("R4", 2);
    exec("R3", 6);
    check("R9", "a [dp+x]", a_o, 8'hC1);
    check("R5", "psw [dp+x]", psw_o, 8'h80);
    exec("R4", 2);
    exec("R3", 6);
    check("R9", "a [dp+x] pointer wrap", a_o, 8'h5E);
    exec("R4", 2);
    exec("R3", 6);
    check("R9", "a [dp]+y", a_o, 8'h00);
    check("R5", "psw [dp]+y", psw_o, 8'h02);
  endtask

  task automatic t_xreg();
    start(8'h20);
    mem[11'h140] = 8'h9F; mem[11'h040] = 8'h11;
    mem[11'h141] = 8'h00; mem[11'h142] = 8'h6B; mem[11'h1FF] = 8'h12;
    put(8'hCD); put(8'h40);
    put(8'hE6);
    put(8'hBF);
    put(8'hBF);
    put(8'hE6);
    put(8'hCD); put(8'hFF);
    put(8'hBF);
    go();
    exec("R4", 2);
    exec("R3", 3);
    check("R8", "a (x) p=1", a_o, 8'h9F);
    check("R8", "x kept", x_o, 8'h40);
    exec("R3", 4);
    check("R8", "a (x)+", a_o, 8'h9F);
    check("R8", "x inc", x_o, 8'h41);
    check("R8", "psw (x)+", psw_o, 8'hA0);
    exec("R3", 4);
    check("R8", "a (x)+ zero", a_o, 8'h00);
    check("R8", "psw (x)+ zero", psw_o, 8'h22);
    exec("R3", 3);
    check("R8", "a (x) after inc", a_o, 8'h6B);
    check("R10", "pc 1-byte ops", pc_o, PROG + 6);
    exec("R4", 2);
    exec("R3", 4);
    check("R8", "a (x)+ at ff", a_o, 8'h12);
    check("R8", "x wraps to 0", x_o, 8'h00);
    check("R8", "flags from data not x", psw_o, 8'h20);
  endtask

  task automatic t_halt();
    int seen = 0;
    start(8'h00);
    put(8'hE8); put(8'h42);
    put(8'h00);
    go();
    exec("R3", 2);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (retire) seen++;
    end
    check("R11", "halted", halted, 1);
    check("R11", "retire count", seen, 0);
    check("R11", "mem_rd", mem_rd, 0);
    check("R11", "a kept", a_o, 8'h42);
    check("R11", "pc past bad op", pc_o, PROG + 3);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_imm();
    t_dp(1'b0);
    t_dp(1'b1);
    t_dp_index();
    t_abs();
    t_indirect();
    t_xreg();
    t_halt();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule